// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core that keeps separate copies of some registers for its privileged modes. Software addresses sixteen logical registers through a 4-bit index. A 5-bit mode input decides which physical copy each logical index reaches. The low eight registers and the program counter are always common. The middle group of five has a private set for the fast-interrupt mode. The stack pointer and link register pair has one copy per exception mode, plus one copy that user and system mode share.

Two combinational read ports and one clocked write port serve the datapath. A second small store keeps one saved status word for each exception mode. It has its own read path and write strobe. When the current mode has no saved status word, an access to that store is refused: it reads zero, changes nothing, and raises an error pulse in the following cycle. Mode sequencing, exception entry and instruction decode belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every physical register and every saved status word to zero, so every logical read in every mode returns zero afterwards.
- R2: Logical indices 0 to 7 reach one physical set in every mode.
- R3: Logical indices 8 to 12 reach a private set in fast-interrupt mode (5'b10001) and one common set in all other modes.
- R4: Logical indices 13 and 14 reach a private pair in each of fast-interrupt (5'b10001), interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) mode, and one pair that user (5'b10000) and system (5'b11111) mode share.
- R5: Logical index 15 reaches one physical register in every mode.
- R6: Both reads are combinational. A write takes effect at the rising edge, and a read of the register being written in that same cycle returns the old value.
- R7: Each of the five exception modes has its own saved status word. sps_rdata shows the current mode's word combinationally, and sps_wr_en writes sps_wdata into it at the rising edge.
- R8: In user or system mode, sps_rdata is zero and sps_wr_en stores nothing. An access there (sps_req or sps_wr_en high) sets sps_err high for exactly the next cycle. sps_err is low after any cycle without such an access.
- R9: A mode value other than the seven listed encodings behaves exactly as user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current processor mode |
| rd0_idx | input | 4 | Logical index, read port 0 |
| rd0_data | output | 32 | Read data, port 0 |
| rd1_idx | input | 4 | Logical index, read port 1 |
| rd1_data | output | 32 | Read data, port 1 |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| sps_req | input | 1 | Saved status read access strobe |
| sps_wr_en | input | 1 | Saved status write strobe |
| sps_wdata | input | 32 | Saved status write data |
| sps_rdata | output | 32 | Saved status word of the current mode |
| sps_err | output | 1 | Refused saved status access, one cycle late |

## Verification
A wrong mapping sends a write to the wrong physical copy. That error stays hidden until another mode reads the index, where it shows up either as a lost value or as a value that leaked between modes. The bench therefore writes a distinct word into every logical index from every mode before it reads anything back. Each mismatch then points to one mode pair and one register group. Errors in the saved status path and in the error pulse show at the ports in the cycle that follows the access, so those checks sample right after that edge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int MODE_W  = 5;
    localparam int LIDX_W  = 4;
    localparam int N_LOG   = 1 << LIDX_W;

    // logical grouping
    localparam int N_LOW    = 8;
    localparam int N_MID    = 5;
    localparam int MID_BASE = N_LOW;
    localparam int SP_IDX   = MID_BASE + N_MID;
    localparam int LR_IDX   = SP_IDX + 1;
    localparam int PC_IDX   = N_LOG - 1;

    // banks: user/system share bank 0, the rest are exception banks
    localparam int N_BANK = 6;
    localparam int N_STK  = 2;

    // physical layout
    localparam int MID_ALT_BASE = MID_BASE + N_MID;
    localparam int STK_BASE     = MID_ALT_BASE + N_MID;
    localparam int PC_SLOT      = STK_BASE + N_STK * N_BANK;
    localparam int PHYS_N       = PC_SLOT + 1;
    localparam int PHYS_W       = $clog2(PHYS_N);

    localparam int SPS_N = N_BANK - 1;
    localparam int SPS_W = $clog2(SPS_N);

    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_COMMON = 3'd0,
        BK_FIQ    = 3'd1,
        BK_IRQ    = 3'd2,
        BK_SVC    = 3'd3,
        BK_ABT    = 3'd4,
        BK_UND    = 3'd5
    } bank_e;

endpackage

// File: rtl/regbank_mode_dec.sv
module regbank_mode_dec
    import regbank_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              has_saved
);

    always_comb begin
        case (mode)
            MD_FIQ:  bank = BK_FIQ;
            MD_IRQ:  bank = BK_IRQ;
            MD_SVC:  bank = BK_SVC;
            MD_ABT:  bank = BK_ABT;
            MD_UND:  bank = BK_UND;
            default: bank = BK_COMMON;   // user, system, unknown (R9)
        endcase
        has_saved = (bank != BK_COMMON);
    end

endmodule

// File: rtl/regbank_map.sv
module regbank_map
    import regbank_pkg::*;
(
    input  bank_e             bank,
    input  logic [LIDX_W-1:0] lidx,
    output logic [PHYS_W-1:0] pidx
);

    int slot;

    always_comb begin
        if (int'(lidx) < MID_BASE) begin
            slot = int'(lidx);
        end else if (int'(lidx) < SP_IDX) begin
            slot = (bank == BK_FIQ) ? MID_ALT_BASE + int'(lidx) - MID_BASE
                                    : int'(lidx);
        end else if (int'(lidx) < PC_IDX) begin
            slot = STK_BASE + N_STK * int'(bank) + int'(lidx) - SP_IDX;
        end else begin
            slot = PC_SLOT;
        end
        pidx = PHYS_W'(slot);
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [LIDX_W-1:0] rd0_idx,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [LIDX_W-1:0] rd1_idx,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [LIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sps_req,
    input  logic              sps_wr_en,
    input  logic [DATA_W-1:0] sps_wdata,
    output logic [DATA_W-1:0] sps_rdata,
    output logic              sps_err
);

    localparam int N_PORT  = 3;
    localparam int WR_PORT = N_PORT - 1;

    typedef struct packed {
        logic [PHYS_N-1:0][DATA_W-1:0] regs;
        logic [SPS_N-1:0][DATA_W-1:0]  sps;
        logic                          err;
    } state_t;

    state_t state_d, state_q;

    bank_e             bank;
    logic              has_saved;
    logic [SPS_W-1:0]  sps_slot;
    logic [LIDX_W-1:0] lidx [N_PORT];
    logic [PHYS_W-1:0] pidx [N_PORT];

    regbank_mode_dec u_dec (
        .mode      (mode),
        .bank      (bank),
        .has_saved (has_saved)
    );

    assign lidx[0]       = rd0_idx;
    assign lidx[1]       = rd1_idx;
    assign lidx[WR_PORT] = wr_idx;

    for (genvar p = 0; p < N_PORT; p++) begin : g_map
        regbank_map u_map (
            .bank (bank),
            .lidx (lidx[p]),
            .pidx (pidx[p])
        );
    end

    always_comb begin
        sps_slot = has_saved ? SPS_W'(int'(bank) - 1) : '0;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.regs[pidx[WR_PORT]] = wr_data;
        end
        if (sps_wr_en && has_saved) begin
            state_d.sps[sps_slot] = sps_wdata;
        end
        state_d.err = (sps_req || sps_wr_en) && !has_saved;
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rd0_data  = state_q.regs[pidx[0]];
    assign rd1_data  = state_q.regs[pidx[1]];
    assign sps_rdata = has_saved ? state_q.sps[sps_slot] : '0;
    assign sps_err   = state_q.err;

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        mode,
    input logic [3:0]        rd0_idx,
    input logic [DATA_W-1:0] rd0_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              sps_req,
    input logic              sps_wr_en,
    input logic [DATA_W-1:0] sps_wdata,
    input logic [DATA_W-1:0] sps_rdata,
    input logic              sps_err
);

    function automatic logic is_exc(input logic [4:0] m);
        return (m == 5'b10001) || (m == 5'b10010) || (m == 5'b10011) ||
               (m == 5'b10111) || (m == 5'b11011);
    endfunction

    logic refused;
    assign refused = (sps_req || sps_wr_en) && !is_exc(mode);

    p_low_shared_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx < 4'd8) |=>
        (rd0_idx != $past(wr_idx) || rd0_data == $past(wr_data)));

    p_pc_shared_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 4'd15) |=>
        (rd0_idx != 4'd15 || rd0_data == $past(wr_data)));

    p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en ##1 ($stable(rd0_idx) && $stable(mode))) |-> $stable(rd0_data));

    p_sps_store_r7: assert property (@(posedge clk) disable iff (rst)
        (sps_wr_en && is_exc(mode) ##1 $stable(mode)) |->
        sps_rdata == $past(sps_wdata));

    p_sps_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !is_exc(mode) |-> sps_rdata == '0);

    p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
        refused |=> sps_err);

    p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !refused |=> !sps_err);

endmodule

bind banked_regfile regbank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .rd0_idx   (rd0_idx),
    .rd0_data  (rd0_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sps_req   (sps_req),
    .sps_wr_en (sps_wr_en),
    .sps_wdata (sps_wdata),
    .sps_rdata (sps_rdata),
    .sps_err   (sps_err)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode = 5'b10000;
    logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0, sps_wdata = '0, sps_rdata;
    logic        wr_en = 1'b0, sps_req = 1'b0, sps_wr_en = 1'b0, sps_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    banked_regfile dut (
        .clk, .rst, .mode,
        .rd0_idx, .rd0_data, .rd1_idx, .rd1_data,
        .wr_en, .wr_idx, .wr_data,
        .sps_req, .sps_wr_en, .sps_wdata, .sps_rdata, .sps_err
    );

    // bench-side mode list: the seven named modes, then one unknown code
    function automatic logic [4:0] mode_at(input int k);
        case (k)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic int group_of(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic bit shares(input logic [4:0] a, input logic [4:0] b, input int r);
        if (r < 8 || r == 15) return 1'b1;
        if (r <= 12) return (group_of(a) == 1) == (group_of(b) == 1);
        return group_of(a) == group_of(b);
    endfunction

    function automatic logic [31:0] val(input int k, input int r);
        return {8'hA5, 8'(k), 8'(r), 8'h3C};
    endfunction

    function automatic logic [31:0] expect_reg(input int k, input int r);
        logic [31:0] e = '0;
        for (int w = 0; w < 8; w++)
            if (shares(mode_at(w), mode_at(k), r)) e = val(w, r);
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic reg_write(input logic [4:0] m, input int r, input logic [31:0] v);
        @(negedge clk);
        mode = m; wr_en = 1'b1; wr_idx = 4'(r); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sps_write(input logic [4:0] m, input logic [31:0] v);
        @(negedge clk);
        mode = m; sps_wr_en = 1'b1; sps_wdata = v;
        @(negedge clk);
        sps_wr_en = 1'b0;
    endtask

    task automatic zero_sweep;
        for (int k = 0; k < 8; k++) begin
            mode = mode_at(k);
            for (int r = 0; r < 16; r++) begin
                rd0_idx = 4'(r); rd1_idx = 4'(15 - r);
                #1;
                check("R1 reg", rd0_data, 32'h0);
                check("R1 reg", rd1_data, 32'h0);
            end
            check("R1 sps", sps_rdata, 32'h0);
        end
    endtask

    string tag;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        zero_sweep;
        check("R8 err after reset", 32'(sps_err), 32'h0);

        // every mode writes every logical index
        for (int k = 0; k < 8; k++)
            for (int r = 0; r < 16; r++)
                reg_write(mode_at(k), r, val(k, r));

        // read back through both ports in every mode
        for (int k = 0; k < 8; k++) begin
            mode = mode_at(k);
            for (int r = 0; r < 16; r++) begin
                rd0_idx = 4'(r); rd1_idx = 4'(r);
                #1;
                if (k == 7)       tag = "R9";
                else if (r < 8)   tag = "R2";
                else if (r <= 12) tag = "R3";
                else if (r <= 14) tag = "R4";
                else              tag = "R5";
                check(tag, rd0_data, expect_reg(k, r));
                check(tag, rd1_data, expect_reg(k, r));
            end
        end

        // R6: a read in the write cycle sees the old value, the new one after the edge
        @(negedge clk);
        mode = 5'b10000; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_BEEF;
        rd0_idx = 4'd3; rd1_idx = 4'd3;
        #1;
        check("R6 old", rd0_data, expect_reg(0, 3));
        check("R6 old", rd1_data, expect_reg(0, 3));
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R6 new", rd0_data, 32'hDEAD_BEEF);
        check("R6 new", rd1_data, 32'hDEAD_BEEF);

        // R7: one word per exception mode
        for (int k = 1; k <= 5; k++) begin
            sps_write(mode_at(k), 32'h5000_0000 + 32'(k));
            #1;
            check("R7 no err", 32'(sps_err), 32'h0);
        end
        for (int k = 1; k <= 5; k++) begin
            mode = mode_at(k);
            #1;
            check("R7 read", sps_rdata, 32'h5000_0000 + 32'(k));
        end

        // R8: refused accesses in user, system and an unknown code
        for (int j = 0; j < 3; j++) begin
            logic [4:0] m;
            m = (j == 0) ? 5'b10000 : (j == 1) ? 5'b11111 : 5'b01010;
            @(negedge clk);
            mode = m; sps_wr_en = 1'b1; sps_wdata = 32'hFFFF_FFFF;
            #1;
            check("R8 zero read", sps_rdata, 32'h0);
            @(negedge clk);
            sps_wr_en = 1'b0;
            #1;
            check("R8 err pulse", 32'(sps_err), 32'h1);
            check("R8 zero read", sps_rdata, 32'h0);
            @(negedge clk);
            #1;
            check("R8 err drop", 32'(sps_err), 32'h0);
        end
        @(negedge clk);
        mode = 5'b11111; sps_req = 1'b1;
        @(negedge clk);
        sps_req = 1'b0;
        #1;
        check("R8 read err", 32'(sps_err), 32'h1);
        for (int k = 1; k <= 5; k++) begin
            mode = mode_at(k);
            #1;
            check("R8 untouched", sps_rdata, 32'h5000_0000 + 32'(k));
        end

        // R1: reset in the middle of traffic
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        zero_sweep;

        summary;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
        $finish;
    end

endmodule